// File: doc/BRIEF.md
# Bunch-Synchronised Sample Enable Generator

This block runs on a fast clock locked to the accelerator and produces the strobes that tell a converter pair when to sample and when to update. A pre-beam trigger arms it. The next usable rising edge of the slow ring-revolution clock then starts a countdown of a programmable number of fast cycles. After that countdown, the block plays one ring period's worth of enable pattern out of a table, one table address per fast cycle.

The table is computed when the design is built, from the bunch spacing and the train length. Between neighbouring bunch peaks, samples are spaced mostly four fast cycles apart, with a few five-cycle steps in the middle of each gap. This makes every gap, and the whole 165-cycle ring period, come out exactly, so one ADC sample lands on every bunch peak. A peak strobe marks those samples. The DAC update strobe trails the ADC strobe by a fixed number of cycles, which covers the processing latency.

Top module: `bunch_sample_sync`

## Requirements
- R1: While `rst_i` is high, all three outputs are low and `sync_dly_i` is captured. Later changes to `sync_dly_i` have no effect until the next reset.
- R2: In the idle state, a high `trig_i` at a clock edge arms the block. The ring input passes two synchroniser stages, so a ring rise first sampled at fast edge k is detected at edge k+2. The qualifying rise is the first one detected at an edge after the one that accepted the trigger. A rise detected at that same edge is not used.
- R3: With latched delay D (0 to 255), the first ADC enable is high in the cycle after fast edge k+3+D, where k is the edge that first sampled the qualifying ring rise high.
- R4: Offsets are counted from that first enable. The table is split into gaps of BUNCH_GAP, BUNCH_GAP and 165 - 2*BUNCH_GAP cycles, one per bunch. Each gap uses the smallest count f of five-cycle steps (0 to 3) that leaves a multiple of four, giving q four-cycle steps. The steps run as q/2 (rounded down) steps of 4, then f steps of 5, then the rest of 4. An ADC enable is issued at the start of every step and at no other offset.
- R5: The peak strobe is high exactly at offsets 0, BUNCH_GAP and 2*BUNCH_GAP, and always together with an ADC enable.
- R6: Each ADC, DAC and peak enable is high for a single fast cycle.
- R7: The DAC enable repeats the ADC enable pattern 4 fast cycles later.
- R8: One sequence spans exactly 165 table addresses and then returns to idle. Without a new trigger, no further enables appear, whatever the ring clock does.
- R9: A trigger that arrives while the block is armed, counting down the delay or playing the table is ignored. The running sequence is unchanged and no second sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast machine-locked clock |
| rst_i | input | 1 | Synchronous active-high reset; also latches the delay |
| ring_clk_i | input | 1 | Ring-revolution clock, asynchronous level |
| trig_i | input | 1 | Pre-beam trigger, sampled on `clk_i` |
| sync_dly_i | input | 8 | Fast-cycle delay from the qualifying ring edge |
| adc_en_o | output | 1 | ADC sample enable, one-cycle pulses |
| dac_en_o | output | 1 | DAC update enable, one-cycle pulses |
| peak_en_o | output | 1 | Marks the ADC sample taken on a bunch peak |

## Verification
The delicate collision is between accepting the trigger and detecting a ring rise at the same fast edge. The bench fires the trigger so that it is sampled exactly on the edge where a rise is detected, and expects the run to start one full ring period later. It also fires one cycle earlier, and expects that same rise to qualify. A second overlap is a trigger arriving while the table plays. That trigger is injected mid-run, and the bench requires the enable pattern to be bit-identical to an undisturbed run and to be followed by silence. Two instances with different bunch spacings are checked against a pattern model built in the bench from R4.

// File: rtl/bunch_sample_sync.sv
module bunch_sample_sync #(
  parameter int RING_CYCLES = 165,
  parameter int BUNCH_GAP   = 55,
  parameter int N_BUNCH     = 3,
  parameter int DLY_W       = 8,
  parameter int DAC_LAG     = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ring_clk_i,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] sync_dly_i,
  output logic             adc_en_o,
  output logic             dac_en_o,
  output logic             peak_en_o
);
  localparam int AW       = $clog2(RING_CYCLES);
  localparam int LAST_LEN = RING_CYCLES - (N_BUNCH - 1) * BUNCH_GAP;

  typedef enum logic [1:0] {IDLE, ARMED, HOLD, RUN} state_t;

  function automatic logic [RING_CYCLES-1:0] adc_map();
    logic [RING_CYCLES-1:0] m;
    int pos, len, n5, n4, lead;
    m   = '0;
    pos = 0;
    for (int k = 0; k < N_BUNCH; k++) begin
      len = (k == N_BUNCH - 1) ? LAST_LEN : BUNCH_GAP;
      n5  = 0;
      for (int j = 3; j >= 0; j--)
        if (((len - 5 * j) % 4) == 0) n5 = j;
      n4   = (len - 5 * n5) / 4;
      lead = n4 / 2;
      for (int s = 0; s < n4 + n5; s++) begin
        m[pos] = 1'b1;
        pos += (s >= lead && s < lead + n5) ? 5 : 4;
      end
    end
    return m;
  endfunction

  function automatic logic [RING_CYCLES-1:0] peak_map();
    logic [RING_CYCLES-1:0] m;
    m = '0;
    for (int k = 0; k < N_BUNCH; k++) m[k * BUNCH_GAP] = 1'b1;
    return m;
  endfunction

  localparam logic [RING_CYCLES-1:0] ADC_ROM  = adc_map();
  localparam logic [RING_CYCLES-1:0] PEAK_ROM = peak_map();

  state_t             state;
  logic [AW-1:0]      addr;
  logic [DLY_W-1:0]   dly_q, cnt;
  logic [2:0]         ring_sr;
  logic [DAC_LAG-1:0] dac_sr;

  wire ring_edge = ring_sr[1] & ~ring_sr[2];
  wire run       = (state == RUN);

  assign dac_en_o = dac_sr[DAC_LAG-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state     <= IDLE;
      addr      <= '0;
      cnt       <= '0;
      dly_q     <= sync_dly_i;
      ring_sr   <= '0;
      dac_sr    <= '0;
      adc_en_o  <= 1'b0;
      peak_en_o <= 1'b0;
    end else begin
      ring_sr   <= {ring_sr[1:0], ring_clk_i};
      adc_en_o  <= run & ADC_ROM[addr];
      peak_en_o <= run & PEAK_ROM[addr];
      dac_sr    <= {dac_sr[DAC_LAG-2:0], adc_en_o};
      case (state)
        IDLE:  if (trig_i) state <= ARMED;
        ARMED: if (ring_edge) begin
                 addr <= '0;
                 if (dly_q == '0) state <= RUN;
                 else begin
                   state <= HOLD;
                   cnt   <= dly_q - 1'b1;
                 end
               end
        HOLD:  if (cnt == '0) state <= RUN;
               else cnt <= cnt - 1'b1;
        RUN:   if (addr == AW'(RING_CYCLES - 1)) state <= IDLE;
               else addr <= addr + 1'b1;
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bunch_sample_sync_chk.sv
module bunch_sample_sync_chk #(
  parameter int AW    = 8,
  parameter int DLY_W = 8,
  parameter int LAST  = 164
) (
  input logic             clk,
  input logic             rst,
  input logic             trig,
  input logic             run,
  input logic [AW-1:0]    addr,
  input logic [DLY_W-1:0] dly,
  input logic             adc,
  input logic             dac,
  input logic             peak
);
  // R6
  adc_single_chk: assert property (@(posedge clk) disable iff (rst) adc |=> !adc);
  // R6
  dac_single_chk: assert property (@(posedge clk) disable iff (rst) dac |=> !dac);
  // R5
  peak_with_adc_chk: assert property (@(posedge clk) disable iff (rst) peak |-> adc);
  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && addr != AW'(LAST)) |=> (run && addr == $past(addr) + AW'(1)));
  // R1
  dly_hold_chk: assert property (@(posedge clk) disable iff (rst) !rst |=> $stable(dly));
  // R9
  retrig_run_chk: assert property (@(posedge clk) disable iff (rst)
    (run && trig && addr != AW'(LAST)) |=> run);
endmodule

bind bunch_sample_sync bunch_sample_sync_chk #(.AW(AW), .DLY_W(DLY_W), .LAST(RING_CYCLES - 1)) chk_i (
  .clk(clk_i), .rst(rst_i), .trig(trig_i), .run(run), .addr(addr), .dly(dly_q),
  .adc(adc_en_o), .dac(dac_en_o), .peak(peak_en_o)
);

// File: tb/bunch_sample_sync_tb_top.sv
module bunch_sample_sync_tb_top;
  localparam int RING = 165;
  localparam int WIN  = 200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ring = 1'b0;
  logic       trig = 1'b0;
  logic [7:0] sdly = 8'd0;
  logic [1:0] adc_w, dac_w, peak_w;
  int cyc = 0, rc = RING - 1;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    rc   <= (rc == RING - 1) ? 0 : rc + 1;
    ring <= (((rc == RING - 1) ? 0 : rc + 1) < 82);
  end

  bunch_sample_sync dut_i (.clk_i(clk), .rst_i(rst), .ring_clk_i(ring), .trig_i(trig),
    .sync_dly_i(sdly), .adc_en_o(adc_w[0]), .dac_en_o(dac_w[0]), .peak_en_o(peak_w[0]));
  bunch_sample_sync #(.BUNCH_GAP(58)) alt_i (.clk_i(clk), .rst_i(rst), .ring_clk_i(ring),
    .trig_i(trig), .sync_dly_i(sdly), .adc_en_o(adc_w[1]), .dac_en_o(dac_w[1]),
    .peak_en_o(peak_w[1]));

  typedef struct packed { logic [7:0] dly; logic [7:0] trc; logic retrig; } vec_t;
  localparam vec_t VECS [6] = '{
    '{8'd0,   8'd100, 1'b0}, '{8'd1,   8'd100, 1'b1}, '{8'd37, 8'd1, 1'b0},
    '{8'd255, 8'd2,   1'b0}, '{8'd5,   8'd2,   1'b1}, '{8'd12, 8'd100, 1'b1}};

  function automatic bit exp_adc(int gap, int r);
    int p = 0;
    for (int k = 0; k < 3; k++) begin
      int len = (k == 2) ? RING - 2 * gap : gap;
      int f = 0;
      int q, h;
      while (((len - 5 * f) % 4) != 0) f++;
      q = (len - 5 * f) / 4;
      h = q / 2;
      for (int s = 0; s < q + f; s++) begin
        if (p == r) return 1'b1;
        p += (s >= h && s < h + f) ? 5 : 4;
      end
    end
    return 1'b0;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic do_reset(logic [7:0] d);
    @(negedge clk); #1;
    rst = 1'b1; sdly = d; trig = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check(adc_w == 0 && dac_w == 0 && peak_w == 0, "R1 outputs low in reset",
          int'({adc_w, dac_w, peak_w}), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    sdly = d ^ 8'hA5;
  endtask

  task automatic run_case(vec_t v);
    int t, k, base, rel, stray, dbl, idle;
    logic [0:WIN-1] oa [2], od [2], op [2];
    logic [1:0] pa, pd, pp;
    do_reset(v.dly);
    do begin @(negedge clk); #1; end while (rc != int'(v.trc));
    t = cyc + 1;
    k = cyc + 1 - int'(v.trc);
    if (v.trc >= 2) k += RING;
    base = k + 3 + int'(v.dly);
    trig = 1'b1;
    for (int i = 0; i < 2; i++) begin oa[i] = '0; od[i] = '0; op[i] = '0; end
    stray = 0; dbl = 0; pa = '0; pd = '0; pp = '0;
    while (cyc < base + WIN - 1) begin
      @(negedge clk); #1;
      trig = 1'b0;
      if (v.retrig && (cyc == t + 3 || cyc == base + 60)) trig = 1'b1;
      rel = cyc - base;
      dbl += $countones((adc_w & pa) | (dac_w & pd) | (peak_w & pp));
      pa = adc_w; pd = dac_w; pp = peak_w;
      for (int i = 0; i < 2; i++) begin
        if (rel >= 0 && rel < WIN) begin
          oa[i][rel] = adc_w[i]; od[i][rel] = dac_w[i]; op[i][rel] = peak_w[i];
        end else if (adc_w[i] | dac_w[i] | peak_w[i]) stray++;
      end
    end
    trig = 1'b0;
    for (int i = 0; i < 2; i++) begin
      int gap = (i == 0) ? 55 : 58;
      int ea = 0, ed = 0, ep = 0, fa = -1, fd = -1, fp = -1;
      for (int r = 0; r < WIN; r++) begin
        bit xa = exp_adc(gap, r);
        bit xd = (r >= 4) ? exp_adc(gap, r - 4) : 1'b0;
        bit xp = (r == 0 || r == gap || r == 2 * gap);
        if (oa[i][r] != xa) begin ea++; if (fa < 0) fa = r; end
        if (od[i][r] != xd) begin ed++; if (fd < 0) fd = r; end
        if (op[i][r] != xp) begin ep++; if (fp < 0) fp = r; end
      end
      check(oa[i][0] == 1'b1, "R3 R1 first ADC enable at k+3+D", int'(oa[i][0]), 1);
      check(ea == 0, "R4 ADC enable offsets (first bad offset)", fa, -1);
      check(ep == 0, "R5 peak strobe offsets (first bad offset)", fp, -1);
      check(ed == 0, "R7 DAC enable lag (first bad offset)", fd, -1);
    end
    check(stray == 0, "R2 R9 no enables outside the run window", stray, 0);
    check(dbl == 0, "R6 single-cycle enables", dbl, 0);
    idle = 0;
    repeat (2 * RING) begin
      @(negedge clk); #1;
      idle += $countones({adc_w, dac_w, peak_w});
    end
    check(idle == 0, "R8 silent after sequence without trigger", idle, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int quiet;
    foreach (VECS[i]) run_case(VECS[i]);
    do_reset(8'd3);
    quiet = 0;
    repeat (3 * RING) begin
      @(negedge clk); #1;
      quiet += $countones({adc_w, dac_w, peak_w});
    end
    check(quiet == 0, "R2 no sequence without trigger", quiet, 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule